// File: doc/BRIEF.md
# Round-Robin Thread-Interleaved Fetch Scheduler

This block decides which of four hardware threads issues into a shared five-stage, single-issue, in-order pipeline on each clock. It also holds one program counter per thread. The rotation is fixed: thread 0, 1, 2, 3, then back to 0. No thread is ever skipped, added or removed. Each thread therefore issues exactly once every four clocks, and that group of four clocks is called one thread cycle.

The execute side of the pipeline reports each thread's resolved next address on the commit inputs. That address is either the sequential successor or a branch target. The report must arrive before the thread's next slot, and the block stores it for that slot. When a thread's memory access has not finished, the execute side flags the commit as a replay. The block then keeps the thread's address unchanged, so the same instruction is issued again in the thread's next slot; the thread is not removed from the rotation. An exception loads a vector into the faulting thread's counter only. The counters of the other threads, and their instructions in flight, are left alone.

The fetch outputs are plain pins with no valid/ready pair. The rotation never waits, so the consumer has no way to apply back-pressure, and every clock after reset carries a fetch. The update inputs are qualified by their own valid pins and are always accepted.

Top module: `rr_fetch_sched`

## Requirements
- R1: The reset is synchronous. On the first clock after it is released, `fetch_tid` is 0 and `tc_strobe` is low. Thread t's counter then holds `RST_BASE + t*RST_STRIDE` (defaults: base 0x0000_0000, stride 0x0000_0100).
- R2: `fetch_tid` advances by exactly one, modulo 4, on every clock. Replays, exceptions and commits never change the order.
- R3: A commit with `cm_valid=1` and `cm_replay=0` writes `cm_next_pc` into thread `cm_tid`'s counter. That thread's next slot fetches this address.
- R4: A commit with `cm_replay=1` leaves the thread's counter unchanged, so the thread's next slot fetches the same address again. `cm_next_pc` is ignored in this case.
- R5: An exception (`ex_valid=1`) loads `ex_vector` into thread `ex_tid`'s counter only. Every other thread keeps fetching the address it would have fetched without the exception.
- R6: `tc_strobe` is high only in a cycle that fetches thread 0 right after a cycle that fetched thread 3. So it is high one cycle in four, and low on the first fetch after reset.
- R7: When an exception and a non-replay commit target the same thread in the same cycle, the exception vector wins.
- R8: An update to a thread made in the cycle that the thread is being fetched does not change the address of that fetch. It takes effect from the thread's following slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cm_valid | input | 1 | Commit report is present |
| cm_tid | input | TID_W | Thread the commit belongs to |
| cm_replay | input | 1 | 1: the memory access is unfinished, keep the counter |
| cm_next_pc | input | ADDR_W | Resolved next address (successor or branch target) |
| ex_valid | input | 1 | Exception redirect is present |
| ex_tid | input | TID_W | Faulting thread |
| ex_vector | input | ADDR_W | Address the faulting thread restarts at |
| fetch_tid | output | TID_W | Thread fetched this cycle |
| fetch_pc | output | ADDR_W | Fetch address of that thread |
| tc_strobe | output | 1 | High on the first slot of each new thread cycle |

## Verification
The bench first lets the rotation run with no updates. This separates the fixed order and the strobe phase from any effect of the counters. Sequential commits made in each thread's own slot show that the write lands one full rotation later and not in the same fetch. A branch target written outside the thread's slot shows that the update is routed to the right thread. A run made only of replays carrying junk addresses tells a hold apart from a write. A single-thread exception, and an exception that collides with a commit, check isolation between threads and the priority of the two updates. A reset in the middle of the run shows that the rotation and the vectors restart.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  // what a thread's counter does at the next edge
  typedef enum logic [1:0] {
    SRC_KEEP   = 2'd0,
    SRC_COMMIT = 2'd1,
    SRC_TRAP   = 2'd2
  } pc_src_e;
endpackage

// File: rtl/rrs_slot_ring.sv
module rrs_slot_ring #(
  parameter int N     = 4,
  parameter int TID_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [TID_W-1:0] slot_o,
  output logic             wrap_o
);
  localparam logic [TID_W-1:0] LAST = TID_W'(N - 1);

  logic [TID_W-1:0] slot_q;
  logic             wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      wrap_q <= (slot_q == LAST);
    end
  end

  assign slot_o = slot_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/rrs_update_sel.sv
module rrs_update_sel #(
  parameter int N     = 4,
  parameter int TID_W = 2,
  parameter int AW    = 32
) (
  input  logic                cm_valid,
  input  logic [TID_W-1:0]    cm_tid,
  input  logic                cm_replay,
  input  logic [AW-1:0]       cm_next_pc,
  input  logic                ex_valid,
  input  logic [TID_W-1:0]    ex_tid,
  input  logic [AW-1:0]       ex_vector,
  output rrs_pkg::pc_src_e    src_o   [N],
  output logic [AW-1:0]       wdata_o [N]
);
  for (genvar t = 0; t < N; t++) begin : g_thr
    logic hit_trap, hit_commit;
    assign hit_trap   = ex_valid && (ex_tid == TID_W'(t));
    assign hit_commit = cm_valid && !cm_replay && (cm_tid == TID_W'(t));

    always_comb begin
      // trap outranks commit for the same thread
      if (hit_trap) begin
        src_o[t]   = rrs_pkg::SRC_TRAP;
        wdata_o[t] = ex_vector;
      end else if (hit_commit) begin
        src_o[t]   = rrs_pkg::SRC_COMMIT;
        wdata_o[t] = cm_next_pc;
      end else begin
        src_o[t]   = rrs_pkg::SRC_KEEP;
        wdata_o[t] = cm_next_pc;
      end
    end
  end
endmodule

// File: rtl/rrs_pc_bank.sv
module rrs_pc_bank #(
  parameter int            N          = 4,
  parameter int            TID_W      = 2,
  parameter int            AW         = 32,
  parameter logic [AW-1:0] RST_BASE   = '0,
  parameter logic [AW-1:0] RST_STRIDE = AW'(256)
) (
  input  logic             clk,
  input  logic             rst,
  input  rrs_pkg::pc_src_e src_i   [N],
  input  logic [AW-1:0]    wdata_i [N],
  input  logic [TID_W-1:0] rd_tid,
  output logic [AW-1:0]    rd_pc
);
  logic [AW-1:0] pc_q [N];

  for (genvar t = 0; t < N; t++) begin : g_pc
    localparam logic [AW-1:0] VEC = RST_BASE + AW'(t) * RST_STRIDE;
    always_ff @(posedge clk) begin
      if (rst)                            pc_q[t] <= VEC;
      else if (src_i[t] != rrs_pkg::SRC_KEEP) pc_q[t] <= wdata_i[t];
    end
  end

  assign rd_pc = pc_q[rd_tid];
endmodule

// File: rtl/rr_fetch_sched.sv
module rr_fetch_sched #(
  parameter int                  N_THREADS  = 4,
  parameter int                  ADDR_W     = 32,
  parameter logic [ADDR_W-1:0]   RST_BASE   = '0,
  parameter logic [ADDR_W-1:0]   RST_STRIDE = ADDR_W'(256),
  localparam int                 TID_W      = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cm_valid,
  input  logic [TID_W-1:0]  cm_tid,
  input  logic              cm_replay,
  input  logic [ADDR_W-1:0] cm_next_pc,
  input  logic              ex_valid,
  input  logic [TID_W-1:0]  ex_tid,
  input  logic [ADDR_W-1:0] ex_vector,
  output logic [TID_W-1:0]  fetch_tid,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              tc_strobe
);
  rrs_pkg::pc_src_e  src   [N_THREADS];
  logic [ADDR_W-1:0] wdata [N_THREADS];
  logic [TID_W-1:0]  slot;

  rrs_slot_ring #(.N(N_THREADS), .TID_W(TID_W)) u_ring (
    .clk(clk), .rst(rst), .slot_o(slot), .wrap_o(tc_strobe)
  );

  rrs_update_sel #(.N(N_THREADS), .TID_W(TID_W), .AW(ADDR_W)) u_sel (
    .cm_valid(cm_valid), .cm_tid(cm_tid), .cm_replay(cm_replay),
    .cm_next_pc(cm_next_pc), .ex_valid(ex_valid), .ex_tid(ex_tid),
    .ex_vector(ex_vector), .src_o(src), .wdata_o(wdata)
  );

  rrs_pc_bank #(
    .N(N_THREADS), .TID_W(TID_W), .AW(ADDR_W),
    .RST_BASE(RST_BASE), .RST_STRIDE(RST_STRIDE)
  ) u_bank (
    .clk(clk), .rst(rst), .src_i(src), .wdata_i(wdata),
    .rd_tid(slot), .rd_pc(fetch_pc)
  );

  assign fetch_tid = slot;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int N     = 4,
  parameter int TID_W = 2,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [TID_W-1:0] fetch_tid,
  input logic [AW-1:0]    fetch_pc,
  input logic             tc_strobe,
  input logic             cm_valid,
  input logic [TID_W-1:0] cm_tid,
  input logic             cm_replay,
  input logic             ex_valid,
  input logic [TID_W-1:0] ex_tid
);
  localparam logic [TID_W-1:0] LAST = TID_W'(N - 1);

  logic          seen_q;
  logic [N-1:0]  fetched_q, dirty_q;
  logic [AW-1:0] last_pc_q [N];

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  for (genvar t = 0; t < N; t++) begin : g_trk
    logic wr;
    assign wr = (cm_valid && !cm_replay && cm_tid == TID_W'(t)) ||
                (ex_valid && ex_tid == TID_W'(t));
    always_ff @(posedge clk) begin
      if (rst) begin
        fetched_q[t] <= 1'b0;
        dirty_q[t]   <= 1'b0;
        last_pc_q[t] <= '0;
      end else if (fetch_tid == TID_W'(t)) begin
        fetched_q[t] <= 1'b1;
        dirty_q[t]   <= wr;
        last_pc_q[t] <= fetch_pc;
      end else if (wr) begin
        dirty_q[t] <= 1'b1;
      end
    end
  end

  // R1: rotation restarts at thread 0 with no strobe
  p_reset_start_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (fetch_tid == '0 && !tc_strobe));

  // R2: one step per clock, wrapping after the last thread
  p_rotate_r2: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> fetch_tid == (($past(fetch_tid) == LAST) ? '0 : $past(fetch_tid) + 1'b1));

  // R6: strobe only on thread 0 slots
  p_strobe_slot_r6: assert property (@(posedge clk) disable iff (rst)
    tc_strobe |-> fetch_tid == '0);

  // R6: every thread 0 slot after the first carries the strobe
  p_strobe_every_r6: assert property (@(posedge clk) disable iff (rst)
    (seen_q && fetch_tid == '0) |-> tc_strobe);

  // R4: with no write since its last slot, a thread refetches the same address
  p_pc_held_r4: assert property (@(posedge clk) disable iff (rst)
    (fetched_q[fetch_tid] && !dirty_q[fetch_tid]) |-> fetch_pc == last_pc_q[fetch_tid]);
endmodule

bind rr_fetch_sched rrs_checker #(.N(N_THREADS), .TID_W(TID_W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .fetch_tid(fetch_tid), .fetch_pc(fetch_pc),
  .tc_strobe(tc_strobe), .cm_valid(cm_valid), .cm_tid(cm_tid),
  .cm_replay(cm_replay), .ex_valid(ex_valid), .ex_tid(ex_tid)
);

// File: tb/sim_rr_fetch_sched.sv
module sim_rr_fetch_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        cm_valid = 1'b0, cm_replay = 1'b0, ex_valid = 1'b0;
  logic [1:0]  cm_tid = '0, ex_tid = '0;
  logic [31:0] cm_next_pc = '0, ex_vector = '0;
  logic [1:0]  fetch_tid;
  logic [31:0] fetch_pc;
  logic        tc_strobe;

  always #5 clk = ~clk;

  rr_fetch_sched u0 (
    .clk(clk), .rst(rst), .cm_valid(cm_valid), .cm_tid(cm_tid),
    .cm_replay(cm_replay), .cm_next_pc(cm_next_pc), .ex_valid(ex_valid),
    .ex_tid(ex_tid), .ex_vector(ex_vector), .fetch_tid(fetch_tid),
    .fetch_pc(fetch_pc), .tc_strobe(tc_strobe)
  );

  typedef struct {
    int          tid;
    logic [31:0] pc;
    bit          strb;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] m_pc [4];
  int          m_slot;
  bit          m_strb;
  int          total = 0, bad = 0;
  bit          done = 0;

  task automatic model_reset();
    for (int t = 0; t < 4; t++) m_pc[t] = 32'h100 * t;
    m_slot = 0;
    m_strb = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cm_valid = 0; cm_replay = 0; ex_valid = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  // called at a falling edge: queue this cycle's expectation, drive, advance model
  task automatic step(input bit cv, input int ct, input bit crep, input logic [31:0] cpc,
                      input bit ev, input int et, input logic [31:0] evec, input string req);
    exp_t e;
    e.tid = m_slot; e.pc = m_pc[m_slot]; e.strb = m_strb; e.req = req;
    sb.push_back(e);
    cm_valid = cv; cm_tid = 2'(ct); cm_replay = crep; cm_next_pc = cpc;
    ex_valid = ev; ex_tid = 2'(et); ex_vector = evec;
    if (cv && !crep) m_pc[ct] = cpc;
    if (ev) m_pc[et] = evec;
    m_strb = (m_slot == 3);
    m_slot = (m_slot + 1) % 4;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(0, 0, 0, 32'h0, 0, 0, 32'h0, req);
  endtask

  // monitor: compare outputs against the queued expectation
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (int'(fetch_tid) != e.tid || fetch_pc !== e.pc || tc_strobe !== e.strb) begin
        bad++;
        $display("FAIL %s: got tid=%0d pc=%h strobe=%b, expected tid=%0d pc=%h strobe=%b",
                 e.req, fetch_tid, fetch_pc, tc_strobe, e.tid, e.pc, e.strb);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got no end, expected end of run");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: first fetch after reset
    idle(1, "R1");
    // R2 and R6: free rotation with reset vectors
    idle(11, "R2_R6");
    // R3 / R8: sequential commit in each thread's own slot, three rounds
    for (int i = 0; i < 12; i++)
      step(1, m_slot, 0, m_pc[m_slot] + 32'd4, 0, 0, 32'h0, "R3_R8");
    idle(4, "R3");
    // R3: branch target for thread 2 reported during thread 0's slot
    while (m_slot != 0) idle(1, "R2");
    step(1, 2, 0, 32'h0000_8000, 0, 0, 32'h0, "R3");
    idle(7, "R3");
    // R4: replay every slot with junk addresses
    for (int i = 0; i < 8; i++)
      step(1, m_slot, 1, 32'hDEAD_0000, 0, 0, 32'h0, "R4");
    idle(4, "R4");
    // R5: exception on thread 2 while thread 1 commits normally
    step(1, 1, 0, 32'h0000_0500, 1, 2, 32'h0000_0F00, "R5");
    idle(8, "R5");
    // R7: exception and commit collide on thread 1
    step(1, 1, 0, 32'h0000_1234, 1, 1, 32'h0000_0E00, "R7");
    idle(8, "R7");
    // R8: update in thread 3's own slot, that fetch keeps the old address
    while (m_slot != 3) idle(1, "R2");
    step(1, 3, 0, 32'h0000_4444, 0, 0, 32'h0, "R8");
    idle(4, "R8");
    // R1: reset in the middle of the run
    do_reset();
    idle(6, "R1");
    @(negedge clk);
    #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule